// File: doc/BRIEF.md
# DLL Enable and Lock Sequencer

This block decides when the output-timing delay-locked loop of a memory interface may be trusted. It runs on a free-running auxiliary clock. It watches an enable request, a clock-stable indication and a frequency-change pulse. It also samples one of two reference clocks as data, choosing either the input-register clock or the output-register clock. Each rising edge of the chosen reference counts as one lock cycle. The DLL is declared locked once a fixed number of edges has been counted under good conditions. The delay line itself is not modelled: the edge counter stands in for it.

Several events throw away any lock progress and force a complete new lock interval:
- the enable request going low;
- the clock-stable indication going low;
- a frequency-change pulse;
- the reference staying idle for longer than a programmable number of auxiliary cycles.

The controller downstream uses `read_block` to hold back reads until lock has been declared.

Top module: `dll_lock_seq`

## Requirements
- R1: During and right after synchronous reset, `dll_enable` is 0, `dll_locked` is 0 and `read_block` is 1.
- R2: `dll_enable` equals `dll_en_req` delayed by one aux cycle. While `dll_en_req` is 0, `dll_locked` is 0 on the next cycle and reference edges are not counted.
- R3: `dll_locked` rises only after exactly LOCK_CYCLES (default 1024) rising edges of the selected reference have been counted while enabled, stable and running. After LOCK_CYCLES-1 edges it is still 0.
- R4: `read_block` is 1 whenever `dll_locked` is 0, and 0 whenever it is 1.
- R5: A one-cycle `freq_change` pulse makes `dll_locked` 0 on the next cycle and restarts the count from zero.
- R6: If the selected reference shows no rising edge for more than STOP_LIMIT aux cycles, `dll_locked` is cleared and the count restarts. The edge that ends the idle period is counted as the first edge of the new interval.
- R7: While `clk_stable` is 0, `dll_locked` is 0 and no edges are counted.
- R8: `use_outclk` = 1 selects `outclk_src` as the reference, and 0 selects `inclk_src`. Edges on the clock that is not selected have no effect on lock.
- R9: Once locked, `dll_locked` stays 1 for as long as the request is high, the clock is stable and running, and no frequency-change pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running auxiliary clock |
| rst | input | 1 | Synchronous active-high reset |
| inclk_src | input | 1 | Input-register reference clock, sampled as data |
| outclk_src | input | 1 | Output-register reference clock, sampled as data |
| use_outclk | input | 1 | 1 selects outclk_src, 0 selects inclk_src |
| dll_en_req | input | 1 | DLL enable request; low holds the DLL disabled |
| clk_stable | input | 1 | Reference clock declared stable |
| freq_change | input | 1 | One-cycle pulse signalling a frequency change |
| dll_enable | output | 1 | Registered DLL enable |
| dll_locked | output | 1 | Registered lock flag |
| read_block | output | 1 | Registered read inhibit, high until lock |

## Verification
The assertions assume two things about the inputs:
- The reference runs at most a quarter of the auxiliary rate, so every reference edge crosses the synchronizer as a clean single-cycle pulse.
- In normal running, the gap between reference edges stays well below STOP_LIMIT.

The stimulus keeps to both. It holds every reference level for four aux cycles and changes inputs only on falling aux edges. It makes a reference idle only when a stop is intended, and then for far longer than STOP_LIMIT. The select input changes only while both references are low, so switching the mux cannot create a false edge.

// File: rtl/dll_seq_pkg.sv
package dll_seq_pkg;
  // width of a counter that must hold values 0..n
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/dll_ref_edge.sv
module dll_ref_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic inclk_src,
  input  logic outclk_src,
  input  logic use_outclk,
  output logic edge_pulse
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] sh;
  logic             picked;

  assign picked = use_outclk ? outclk_src : inclk_src;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[CHAIN-2:0], picked};
  end

  // rising edge seen after the synchronizer stages
  assign edge_pulse = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
endmodule

// File: rtl/dll_stop_watch.sv
module dll_stop_watch
  import dll_seq_pkg::*;
#(
  parameter int STOP_LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_pulse,
  output logic stopped
);
  localparam int IW = cnt_w(STOP_LIMIT);

  logic [IW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cnt <= '0;
      stopped  <= 1'b0;
    end else if (edge_pulse) begin
      idle_cnt <= '0;
      stopped  <= 1'b0;
    end else if (idle_cnt == IW'(STOP_LIMIT)) begin
      stopped  <= 1'b1;
    end else begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dll_lock_counter.sv
module dll_lock_counter
  import dll_seq_pkg::*;
#(
  parameter int LOCK_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic en_req,
  input  logic stable,
  input  logic stopped,
  input  logic freq_change,
  input  logic edge_pulse,
  output logic locked,
  output logic read_block
);
  localparam int CW = cnt_w(LOCK_CYCLES);

  logic [CW-1:0] cnt;
  logic          hard_clear;

  assign hard_clear = !en_req || !stable || freq_change;

  always_ff @(posedge clk) begin
    if (rst || hard_clear || (stopped && !edge_pulse)) begin
      cnt        <= '0;
      locked     <= 1'b0;
      read_block <= 1'b1;
    end else if (edge_pulse && !locked) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(LOCK_CYCLES - 1)) begin
        locked     <= 1'b1;
        read_block <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dll_lock_seq.sv
module dll_lock_seq #(
  parameter int LOCK_CYCLES = 1024,
  parameter int STOP_LIMIT  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic inclk_src,
  input  logic outclk_src,
  input  logic use_outclk,
  input  logic dll_en_req,
  input  logic clk_stable,
  input  logic freq_change,
  output logic dll_enable,
  output logic dll_locked,
  output logic read_block
);
  logic ref_edge;
  logic ref_stopped;

  dll_ref_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .inclk_src(inclk_src), .outclk_src(outclk_src),
    .use_outclk(use_outclk), .edge_pulse(ref_edge)
  );

  dll_stop_watch #(.STOP_LIMIT(STOP_LIMIT)) u_stop (
    .clk(clk), .rst(rst), .edge_pulse(ref_edge), .stopped(ref_stopped)
  );

  dll_lock_counter #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .rst(rst), .en_req(dll_en_req), .stable(clk_stable),
    .stopped(ref_stopped), .freq_change(freq_change), .edge_pulse(ref_edge),
    .locked(dll_locked), .read_block(read_block)
  );

  always_ff @(posedge clk) begin
    if (rst) dll_enable <= 1'b0;
    else     dll_enable <= dll_en_req;
  end
endmodule

// File: rtl/dll_lock_seq_chk.sv
module dll_lock_seq_chk
  import dll_seq_pkg::*;
#(
  parameter int LOCK_CYCLES = 1024
) (
  input logic clk,
  input logic rst,
  input logic dll_en_req,
  input logic clk_stable,
  input logic freq_change,
  input logic ref_edge,
  input logic ref_stopped,
  input logic dll_enable,
  input logic dll_locked,
  input logic read_block
);
  localparam int CW = cnt_w(LOCK_CYCLES);

  logic [CW-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst || !dll_en_req || !clk_stable || freq_change || (ref_stopped && !ref_edge))
      seen <= '0;
    else if (ref_edge && seen != CW'(LOCK_CYCLES))
      seen <= seen + 1'b1;
  end

  // R2
  enable_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> dll_enable == $past(dll_en_req));
  // R2
  off_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !dll_en_req |=> !dll_locked);
  // R3
  lock_count_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dll_locked) |-> seen == CW'(LOCK_CYCLES));
  // R4
  block_inverse_chk: assert property (@(posedge clk) disable iff (rst)
    read_block != dll_locked);
  // R5
  freq_clears_chk: assert property (@(posedge clk) disable iff (rst)
    freq_change |=> !dll_locked);
  // R6
  stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_stopped && !ref_edge) |=> !dll_locked);
  // R7
  unstable_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !clk_stable |=> !dll_locked);
  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dll_locked && dll_en_req && clk_stable && !freq_change && !ref_stopped) |=> dll_locked);
endmodule

bind dll_lock_seq dll_lock_seq_chk #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .dll_en_req(dll_en_req), .clk_stable(clk_stable),
  .freq_change(freq_change), .ref_edge(ref_edge), .ref_stopped(ref_stopped),
  .dll_enable(dll_enable), .dll_locked(dll_locked), .read_block(read_block)
);

// File: tb/tb_dll_lock_seq.sv
`timescale 1ns/1ps
module tb_dll_lock_seq;
  localparam int LOCK = 1024;
  localparam int STOP = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inclk_src = 1'b0, outclk_src = 1'b0, use_outclk = 1'b0;
  logic dll_en_req = 1'b0, clk_stable = 1'b0, freq_change = 1'b0;
  logic dll_enable, dll_locked, read_block;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dll_lock_seq #(.LOCK_CYCLES(LOCK), .STOP_LIMIT(STOP), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .inclk_src(inclk_src), .outclk_src(outclk_src),
    .use_outclk(use_outclk), .dll_en_req(dll_en_req), .clk_stable(clk_stable),
    .freq_change(freq_change), .dll_enable(dll_enable), .dll_locked(dll_locked),
    .read_block(read_block)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", req, act, exp);
    end
  endtask

  // n reference cycles, each four aux cycles high and four low
  task automatic pulses(input int n, input bit on_out);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (on_out) outclk_src = 1'b1; else inclk_src = 1'b1;
      repeat (4) @(negedge clk);
      if (on_out) outclk_src = 1'b0; else inclk_src = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic relock(input string req, input bit on_out);
    pulses(LOCK - 1, on_out);
    chk(req, dll_locked, 1'b0);
    pulses(1, on_out);
    chk(req, dll_locked, 1'b1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected below 190000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 enable", dll_enable, 1'b0);
    chk("R1 locked", dll_locked, 1'b0);
    chk("R1 block", read_block, 1'b1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 locked after release", dll_locked, 1'b0);

    // R2 request low: nothing counted
    clk_stable = 1'b1;
    pulses(LOCK + 50, 1'b0);
    chk("R2 locked while off", dll_locked, 1'b0);
    chk("R2 enable while off", dll_enable, 1'b0);

    // R3 exact lock count, R4 inverse, R9 hold
    dll_en_req = 1'b1;
    @(negedge clk);
    chk("R2 enable follows", dll_enable, 1'b1);
    relock("R3", 1'b0);
    chk("R4 block when locked", read_block, 1'b0);
    pulses(100, 1'b0);
    chk("R9 hold", dll_locked, 1'b1);

    // R5 frequency change
    @(negedge clk); freq_change = 1'b1;
    @(negedge clk); freq_change = 1'b0;
    chk("R5 cleared", dll_locked, 1'b0);
    chk("R4 block when unlocked", read_block, 1'b1);
    pulses(600, 1'b0);
    @(negedge clk); freq_change = 1'b1;
    @(negedge clk); freq_change = 1'b0;
    relock("R5", 1'b0);

    // R6 stopped reference
    repeat (40) @(negedge clk);
    chk("R6 cleared on stop", dll_locked, 1'b0);
    chk("R6 block on stop", read_block, 1'b1);
    relock("R6", 1'b0);

    // R7 unstable clock
    clk_stable = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 cleared", dll_locked, 1'b0);
    pulses(LOCK + 20, 1'b0);
    chk("R7 no count", dll_locked, 1'b0);
    clk_stable = 1'b1;
    relock("R7", 1'b0);

    // R2 request dropped while locked
    dll_en_req = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 cleared by request", dll_locked, 1'b0);
    chk("R2 enable drops", dll_enable, 1'b0);
    dll_en_req = 1'b1;

    // R8 source select
    use_outclk = 1'b1;
    pulses(LOCK + 80, 1'b0);
    chk("R8 unselected ignored", dll_locked, 1'b0);
    relock("R8", 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule